// File: doc/BRIEF.md
# Expansion-Bus Interface Register Slave

This block is the register front end of a CPU-side expansion-bus interface. It accepts byte, word and longword accesses, one at a time, through a valid/ready request channel. It answers each one with a single response beat on a valid/ready response channel. The caller selects one of two address windows with a window input. Both windows respond to the same byte-wide register set.

The direct window holds a 32-bit control word that can be read and written. It also holds a 32-bit board identity word that can only be written there. The slot window is a sparse region at the very top of a 16 MiB slot space. In it, an interrupt flag, an interrupt enable and the four identity bytes each occupy the first byte of their own longword. The remaining bytes of those longwords read as zero. Every access is broken into big-endian byte lanes and decoded lane by lane. A single failing lane, a misaligned address or an unmapped offset turns the whole transfer into a bus-error response, and that transfer changes no state.

An external event input sets a sticky interrupt flag. The interrupt output is the flag gated by the enable bit. The control word's upper flags (slot-ID low-bit ignore at bit 28, store-forward at bit 27, read-modify collision at bit 26) are only stored and returned. The identity word carries a valid flag in bit 31, a 15-bit maker code in bits 30..16 and a 16-bit board code in bits 15..0.

Top module: `xbus_regslave`

## Requirements
- R1: A request is taken on a clock edge where req_valid and req_ready are both high, and req_ready equals !rsp_valid || rsp_ready. The response shows rsp_valid high from the next cycle on. rsp_rdata and rsp_err stay unchanged while rsp_ready is low.
- R2: req_size encodes 0 = byte, 1 = word, 2 = longword; the value 3 is a bus error. A word at an odd address, or a longword at an address whose two low bits are not both zero, is a bus error. Read data and write data are right-justified, and the lowest address sits in the most significant byte of that data.
- R3: In the direct window (req_win = 0), byte offsets 0..3 (address bits 2..0) read and write the control word, offset 0 being bits 31..24. All 32 bits are stored as written.
- R4: In the direct window, offsets 4..7 write the identity word (offset 4 = bits 31..24), and reading them is a bus error. Any direct access whose address bits 15..0 exceed 7 is a bus error.
- R5: In the slot window (req_win = 1), any access with address bits 23..0 below 0xFFFFE8 is a bus error. Otherwise, address bits 4..0 give the offset, and offsets 0..7 are a bus error.
- R6: Slot offset 8 reads the interrupt flag in bit 7, and a write to it is a bus error. Offset 12 reads and writes the interrupt enable, and only bit 7 is kept. Offsets 9..11 and 13..15 read as zero, and writes to them are accepted without error and change nothing.
- R7: Slot offsets 16, 20, 24 and 28 read identity bits 31..24, 23..16, 15..8 and 7..0. The other bytes in offsets 16..31 read as zero. Every write in offsets 16..31 is a bus error.
- R8: An errored response carries zero data. An errored write leaves the control word, identity and enable unchanged. A write response carries zero data.
- R9: After reset the control word, identity, interrupt flag and enable are zero, no response is pending, and irq_out is low.
- R10: irq_set high at a clock edge sets the interrupt flag, which stays set until reset. irq_out is high exactly when both the flag and the enable are set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_win | input | 1 | 0 = direct window, 1 = slot window |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | 0 byte, 1 word, 2 longword |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Right-justified write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken this cycle |
| rsp_rdata | output | 32 | Right-justified read data |
| rsp_err | output | 1 | Bus-error response |
| irq_set | input | 1 | Sets the interrupt flag |
| irq_out | output | 1 | Flag AND enable |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a direct window decoded on 16 low bits and a slot window decoded on 24 low bits. With these values the bench can drive full bus addresses whose upper bits are set and must be ignored. It can also step across the 0xFFFFE8 slot floor and the offset-7 edge of the direct window. A 24-bit slot decode also puts the alias-free top 32-byte region within reach. There, longword reads gather one register byte together with three zero bytes.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int LANES = 4;

  typedef logic [1:0] tgt_t;
  localparam tgt_t TGT_NONE = 2'd0;
  localparam tgt_t TGT_CTRL = 2'd1;
  localparam tgt_t TGT_ID   = 2'd2;
  localparam tgt_t TGT_MASK = 2'd3;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;
  localparam logic [1:0] SZ_LONG = 2'd2;

  // big-endian byte pick: index 0 is bits 31..24
  function automatic logic [7:0] be_byte(input logic [31:0] w, input logic [1:0] i);
    case (i)
      2'd0:    be_byte = w[31:24];
      2'd1:    be_byte = w[23:16];
      2'd2:    be_byte = w[15:8];
      default: be_byte = w[7:0];
    endcase
  endfunction
endpackage

// File: rtl/xbus_lane_dec.sv
module xbus_lane_dec
  import xbus_pkg::*;
(
  input  logic        win,
  input  logic        wr,
  input  logic [4:0]  off,
  input  logic [31:0] ctrl,
  input  logic [31:0] id,
  input  logic        status,
  input  logic        mask,
  output logic        err,
  output logic [7:0]  rbyte,
  output tgt_t        tgt,
  output logic [1:0]  tidx
);
  always_comb begin
    err   = 1'b0;
    rbyte = 8'h00;
    tgt   = TGT_NONE;
    tidx  = off[1:0];
    if (!win) begin
      // direct window: control bytes then identity bytes
      if (!off[2]) begin
        rbyte = be_byte(ctrl, off[1:0]);
        if (wr) tgt = TGT_CTRL;
      end else if (wr) begin
        tgt = TGT_ID;
      end else begin
        err = 1'b1;
      end
    end else begin
      case (off[4:3])
        2'b00: err = 1'b1;
        2'b01: begin
          if (off[2:0] == 3'd0) begin
            if (wr) err = 1'b1;
            else    rbyte = {status, 7'b0};
          end else if (off[2:0] == 3'd4) begin
            rbyte = {mask, 7'b0};
            if (wr) tgt = TGT_MASK;
          end
        end
        default: begin
          if (wr) err = 1'b1;
          else if (off[1:0] == 2'd0) begin
            tidx  = off[3:2];
            rbyte = be_byte(id, off[3:2]);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/xbus_regfile.sv
module xbus_regfile
  import xbus_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] lane_wen,
  input  tgt_t             tgt   [LANES],
  input  logic [1:0]       tidx  [LANES],
  input  logic [7:0]       wbyte [LANES],
  input  logic             irq_set,
  output logic [31:0]      ctrl_q,
  output logic [31:0]      id_q,
  output logic             status_q,
  output logic             mask_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      id_q     <= '0;
      status_q <= 1'b0;
      mask_q   <= 1'b0;
    end else begin
      if (irq_set) status_q <= 1'b1;
      for (int l = 0; l < LANES; l++) begin
        if (lane_wen[l]) begin
          if (tgt[l] == TGT_MASK) mask_q <= wbyte[l][7];
          for (int b = 0; b < 4; b++) begin
            if (tidx[l] == 2'(b)) begin
              if (tgt[l] == TGT_CTRL) ctrl_q[8*(3-b) +: 8] <= wbyte[l];
              if (tgt[l] == TGT_ID)   id_q[8*(3-b) +: 8]   <= wbyte[l];
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/xbus_regslave.sv
module xbus_regslave
  import xbus_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int DIR_LOW_BITS  = 16,
  parameter int SLOT_LOW_BITS = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_win,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  input  logic              irq_set,
  output logic              irq_out
);
  localparam logic [SLOT_LOW_BITS-1:0] SLOT_FLOOR = {SLOT_LOW_BITS{1'b1}} - SLOT_LOW_BITS'(23);

  logic [31:0] ctrl_q, id_q;
  logic        status_q, mask_q;

  logic             acc;
  logic [LANES-1:0] lane_en, lane_err, lane_wen;
  logic [7:0]       rb  [LANES];
  logic [7:0]       wb  [LANES];
  tgt_t             tgt [LANES];
  logic [1:0]       tidx[LANES];
  logic             size_bad, misal, range_bad, any_err;
  logic [31:0]      rd_asm;

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;

  // size and alignment
  always_comb begin
    size_bad = 1'b0;
    misal    = 1'b0;
    lane_en  = '0;
    case (req_size)
      SZ_BYTE: lane_en = 4'b0001;
      SZ_WORD: begin lane_en = 4'b0011; misal = req_addr[0]; end
      SZ_LONG: begin lane_en = 4'b1111; misal = |req_addr[1:0]; end
      default: size_bad = 1'b1;
    endcase
  end

  // window range
  always_comb begin
    if (req_win) range_bad = req_addr[SLOT_LOW_BITS-1:0] < SLOT_FLOOR;
    else         range_bad = |req_addr[DIR_LOW_BITS-1:3];
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    xbus_lane_dec u_dec (
      .win   (req_win),
      .wr    (req_write),
      .off   (req_addr[4:0] + 5'(g)),
      .ctrl  (ctrl_q),
      .id    (id_q),
      .status(status_q),
      .mask  (mask_q),
      .err   (lane_err[g]),
      .rbyte (rb[g]),
      .tgt   (tgt[g]),
      .tidx  (tidx[g])
    );
  end

  assign any_err  = size_bad || misal || range_bad || |(lane_err & lane_en);
  assign lane_wen = (acc && req_write && !any_err) ? lane_en : '0;

  // big-endian lane steering
  always_comb begin
    for (int l = 0; l < LANES; l++) wb[l] = 8'h00;
    rd_asm = '0;
    case (req_size)
      SZ_BYTE: begin
        wb[0]  = req_wdata[7:0];
        rd_asm = {24'h0, rb[0]};
      end
      SZ_WORD: begin
        wb[0]  = req_wdata[15:8];
        wb[1]  = req_wdata[7:0];
        rd_asm = {16'h0, rb[0], rb[1]};
      end
      SZ_LONG: begin
        wb[0]  = req_wdata[31:24];
        wb[1]  = req_wdata[23:16];
        wb[2]  = req_wdata[15:8];
        wb[3]  = req_wdata[7:0];
        rd_asm = {rb[0], rb[1], rb[2], rb[3]};
      end
      default: ;
    endcase
  end

  xbus_regfile u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .lane_wen(lane_wen),
    .tgt     (tgt),
    .tidx    (tidx),
    .wbyte   (wb),
    .irq_set (irq_set),
    .ctrl_q  (ctrl_q),
    .id_q    (id_q),
    .status_q(status_q),
    .mask_q  (mask_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else if (acc) begin
      rsp_valid <= 1'b1;
      rsp_err   <= any_err;
      rsp_rdata <= (req_write || any_err) ? 32'h0 : rd_asm;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign irq_out = status_q && mask_q;
endmodule

// File: rtl/xbus_regslave_chk.sv
module xbus_regslave_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_win,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_size,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [31:0]       rsp_rdata,
  input logic              rsp_err,
  input logic              irq_set,
  input logic [31:0]       ctrl_q,
  input logic [31:0]       id_q,
  input logic              status_q,
  input logic              mask_q
);
  logic take;
  assign take = req_valid && req_ready;

  a_r1_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_err));

  a_r1_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> rsp_valid);

  a_r2_bad_size: assert property (@(posedge clk) disable iff (!rst_n)
    take && req_size == 2'd3 |=> rsp_err);

  a_r2_odd_word: assert property (@(posedge clk) disable iff (!rst_n)
    take && req_size == 2'd1 && req_addr[0] |=> rsp_err);

  a_r5_slot_low: assert property (@(posedge clk) disable iff (!rst_n)
    take && req_win && req_addr[4:3] == 2'b00 |=> rsp_err);

  a_r8_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_rdata == 32'h0);

  a_r8_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    take && req_write |=> (rsp_err -> ($stable(ctrl_q) && $stable(id_q) && $stable(mask_q))));

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    status_q |=> status_q);

  a_r10_set: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> status_q);
endmodule

bind xbus_regslave xbus_regslave_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/xbus_regslave_test.sv
module xbus_regslave_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_win = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_size = '0;
  logic        rsp_ready = 1'b0, irq_set = 1'b0;
  logic        req_ready, rsp_valid, rsp_err, irq_out;
  logic [31:0] rsp_rdata;

  int total = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_regslave uut (.*);

  localparam logic [31:0] DIR  = 32'h0202_0000;
  localparam logic [31:0] SLOT = 32'hF0FF_FFE0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic win, input logic [31:0] addr, input logic [1:0] sz,
                      input logic wr, input logic [31:0] wd,
                      output logic [31:0] rd, output logic er);
    @(negedge clk);
    req_valid = 1; req_win = win; req_addr = addr; req_size = sz;
    req_write = wr; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    rd = rsp_rdata; er = rsp_err;
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d; logic e;
    chk("R9 rsp_valid after reset", 32'(rsp_valid), 0);
    chk("R9 irq_out after reset", 32'(irq_out), 0);
    xfer(0, DIR, 2, 0, 0, d, e);
    chk("R9 ctrl zero", d, 0);
    xfer(1, SLOT + 8, 2, 0, 0, d, e);
    chk("R9 flag zero", d, 0);
  endtask

  task automatic t_ctrl;
    logic [31:0] d; logic e;
    xfer(0, DIR, 2, 1, 32'h1C00_A5F0, d, e);
    chk("R3 long write err", 32'(e), 0);
    chk("R8 write rsp data zero", d, 0);
    xfer(0, DIR, 2, 0, 0, d, e);
    chk("R3 long readback", d, 32'h1C00_A5F0);
    xfer(0, DIR, 0, 0, 0, d, e);
    chk("R3 byte 0 is msb", d, 32'h1C);
    xfer(0, DIR + 2, 1, 0, 0, d, e);
    chk("R2 word at 2 big-endian", d, 32'hA5F0);
    xfer(0, DIR + 1, 0, 1, 32'h77, d, e);
    xfer(0, DIR, 2, 0, 0, d, e);
    chk("R3 byte write merge", d, 32'h1C77_A5F0);
  endtask

  task automatic t_ident;
    logic [31:0] d; logic e;
    xfer(0, DIR + 4, 2, 0, 0, d, e);
    chk("R4 id read err", 32'(e), 1);
    chk("R8 err data zero", d, 0);
    xfer(0, DIR + 5, 0, 0, 0, d, e);
    chk("R4 id byte read err", 32'(e), 1);
    xfer(0, DIR + 4, 2, 1, 32'h8123_4567, d, e);
    chk("R4 id write ok", 32'(e), 0);
    xfer(0, DIR + 8, 0, 0, 0, d, e);
    chk("R4 offset 8 err", 32'(e), 1);
    xfer(0, DIR + 32'h10, 2, 1, 32'hFFFF_FFFF, d, e);
    chk("R4 far write err", 32'(e), 1);
    xfer(0, DIR, 2, 0, 0, d, e);
    chk("R8 ctrl untouched by far write", d, 32'h1C77_A5F0);
  endtask

  task automatic t_slot_id;
    logic [31:0] d; logic e;
    xfer(1, SLOT + 16, 2, 0, 0, d, e);
    chk("R7 long at 16", d, 32'h8100_0000);
    xfer(1, SLOT + 20, 0, 0, 0, d, e);
    chk("R7 byte 20", d, 32'h23);
    xfer(1, SLOT + 24, 1, 0, 0, d, e);
    chk("R7 word at 24", d, 32'h4500);
    xfer(1, SLOT + 28, 0, 0, 0, d, e);
    chk("R7 byte 28", d, 32'h67);
    xfer(1, SLOT + 17, 0, 0, 0, d, e);
    chk("R7 byte 17 zero", d, 0);
    xfer(1, SLOT + 16, 0, 1, 32'h11, d, e);
    chk("R7 write err", 32'(e), 1);
    xfer(1, SLOT + 16, 0, 0, 0, d, e);
    chk("R7 id unchanged", d, 32'h81);
  endtask

  task automatic t_flag_mask;
    logic [31:0] d; logic e;
    xfer(1, SLOT + 8, 0, 1, 32'hFF, d, e);
    chk("R6 flag write err", 32'(e), 1);
    xfer(1, SLOT + 12, 0, 1, 32'hFF, d, e);
    chk("R6 mask write ok", 32'(e), 0);
    xfer(1, SLOT + 12, 2, 0, 0, d, e);
    chk("R6 mask bit7 only", d, 32'h8000_0000);
    chk("R10 no irq without flag", 32'(irq_out), 0);
    xfer(1, SLOT + 9, 0, 1, 32'h55, d, e);
    chk("R6 reserved write no err", 32'(e), 0);
    xfer(1, SLOT + 8, 2, 0, 0, d, e);
    chk("R6 reserved reads zero", d, 0);
    @(negedge clk); irq_set = 1;
    @(negedge clk); irq_set = 0;
    chk("R10 irq asserted", 32'(irq_out), 1);
    repeat (2) @(negedge clk);
    chk("R10 flag sticky", 32'(irq_out), 1);
    xfer(1, SLOT + 8, 2, 0, 0, d, e);
    chk("R6 flag read", d, 32'h8000_0000);
    xfer(1, SLOT + 12, 0, 1, 32'h7F, d, e);
    chk("R10 mask off drops irq", 32'(irq_out), 0);
  endtask

  task automatic t_slot_range;
    logic [31:0] d; logic e;
    xfer(1, SLOT, 0, 0, 0, d, e);
    chk("R5 offset 0 err", 32'(e), 1);
    xfer(1, SLOT + 7, 0, 0, 0, d, e);
    chk("R5 offset 7 err", 32'(e), 1);
    xfer(1, 32'hF0FF_FF08, 0, 0, 0, d, e);
    chk("R5 below floor err", 32'(e), 1);
    xfer(1, 32'h00FF_FFE8, 0, 0, 0, d, e);
    chk("R5 upper bits ignored", 32'(e), 0);
  endtask

  task automatic t_align;
    logic [31:0] d; logic e;
    xfer(0, DIR + 1, 1, 0, 0, d, e);
    chk("R2 odd word err", 32'(e), 1);
    xfer(0, DIR + 2, 2, 0, 0, d, e);
    chk("R2 long at 2 err", 32'(e), 1);
    xfer(0, DIR, 3, 0, 0, d, e);
    chk("R2 size 3 err", 32'(e), 1);
    xfer(0, DIR + 1, 2, 1, 32'hFFFF_FFFF, d, e);
    chk("R8 misaligned write err", 32'(e), 1);
    xfer(0, DIR, 2, 0, 0, d, e);
    chk("R8 misaligned write suppressed", d, 32'h1C77_A5F0);
  endtask

  task automatic t_backpressure;
    logic [31:0] d0;
    @(negedge clk);
    req_valid = 1; req_win = 0; req_addr = DIR; req_size = 2; req_write = 0;
    @(negedge clk);
    req_valid = 0;
    d0 = rsp_rdata;
    chk("R1 response shown", 32'(rsp_valid), 1);
    chk("R1 ready low while held", 32'(req_ready), 0);
    repeat (3) @(negedge clk);
    chk("R1 still valid", 32'(rsp_valid), 1);
    chk("R1 data stable", rsp_rdata, d0);
    chk("R1 data value", d0, 32'h1C77_A5F0);
    rsp_ready = 1;
    #1;
    chk("R1 ready with rsp_ready", 32'(req_ready), 1);
    @(negedge clk);
    rsp_ready = 0;
    chk("R1 response retired", 32'(rsp_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_ctrl();
    t_ident();
    t_slot_id();
    t_flag_mask();
    t_slot_range();
    t_align();
    t_backpressure();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule